// File: doc/BRIEF.md
# Multi-Mode Content Addressable Memory

This block is a sixteen-entry content addressable memory whose entries each hold one byte. A search presents an 8-bit key, and the block answers with a 16-bit vector that has one bit per entry. Next to the vector it gives a hit flag and the binary index of the lowest entry that matched. A separate write port loads a byte into any entry and marks that entry as holding data.

Each operation is requested for one cycle on the operation port, and a mode code picks the operation. A single-match search reports at most one entry, and that entry is the lowest-numbered hit. A multiple-match search reports every entry that hit. A clear empties the whole array in one cycle. Search results are registered. They appear one clock after the request and stay on the outputs until the next search or clear.

Top module: `cam_multimode`

## Requirements
- R1: While rst is high and in the cycle after it falls, matchVec, matchFound and matchIdx are zero, and every entry is empty. A search issued straight after reset reports no hit for any key, 0x00 included.
- R2: When wrEn is high at a clock edge and no clear is requested in that cycle, wrData is stored in entry wrAddr and that entry becomes valid. A later search for that byte reports the entry.
- R3: With opEn high and opMode 2'b01 (multiple match), the outputs after the next clock edge have bit i of matchVec set for every valid entry i that holds searchKey, and every other bit clear.
- R4: With opEn high and opMode 2'b00 (single match), the outputs after the next clock edge have only the bit of the lowest-numbered valid entry that holds searchKey set. If no entry holds the key, the vector is zero.
- R5: matchFound equals the OR of the bits of matchVec. matchIdx is the position of the lowest set bit of matchVec, and it is 0 when matchVec is zero.
- R6: An entry that has never been written since reset or the last clear never sets its match bit, whatever the key.
- R7: With opEn high and opMode 2'b10 (clear), every entry becomes empty at that clock edge and all three outputs are zero after it. A write requested in the same cycle is discarded.
- R8: A search and a write in the same cycle compare the key against the contents as they stood before that edge. The new byte only takes part in later searches.
- R9: When opEn is low, or opMode is 2'b11, the outputs keep their values across the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opEn | input | 1 | Operation request for this cycle |
| opMode | input | 2 | 00 single match, 01 multiple match, 10 clear, 11 no operation |
| searchKey | input | 8 | Byte to search for |
| wrEn | input | 1 | Write request |
| wrAddr | input | 4 | Entry to write |
| wrData | input | 8 | Byte to store |
| matchVec | output | 16 | Registered per-entry match bits |
| matchFound | output | 1 | High when any bit of matchVec is set |
| matchIdx | output | 4 | Lowest set position of matchVec |

## Verification
The bench stores one key in three entries that are not adjacent. It then searches in both modes. A priority picker that chose the highest hit would report entry 12 instead of entry 3, and one that skipped the single-match filter would return three bits. One search runs in the same cycle as a write to the entry it hits. A design that forwarded the new byte would lose the old hit there and gain a false hit for the new byte. One clear runs in the same cycle as a write, and a design that let the write through would still hit afterward. A search for 0x00 on an empty array and idle cycles that follow a nonzero result expose entries that match without valid data and outputs that do not hold.

// File: rtl/cam_pkg.sv
package cam_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_MULTI  = 2'b01,
    MODE_CLEAR  = 2'b10,
    MODE_IDLE   = 2'b11
  } camMode_e;

  typedef struct packed {
    logic doSearch;
    logic pickLowest;
    logic doClear;
    logic doWrite;
  } camStrobe_t;

endpackage

// File: rtl/cam_ctrl.sv
module cam_ctrl
  import cam_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       opEn,
  input  logic [1:0] opMode,
  input  logic       wrEn,
  output camStrobe_t stb
);

  camMode_e modeSel;

  always_comb begin
    modeSel        = camMode_e'(opMode);
    stb.doSearch   = 1'b0;
    stb.pickLowest = 1'b0;
    stb.doClear    = 1'b0;
    if (opEn) begin
      unique case (modeSel)
        MODE_SINGLE: begin
          stb.doSearch   = 1'b1;
          stb.pickLowest = 1'b1;
        end
        MODE_MULTI:  stb.doSearch = 1'b1;
        MODE_CLEAR:  stb.doClear  = 1'b1;
        default: ;
      endcase
    end
    stb.doWrite = wrEn && !stb.doClear;
  end

  AST_CLEAR_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (opEn && opMode == 2'b10) |-> !stb.doWrite); // R7

endmodule

// File: rtl/cam_entry.sv
module cam_entry #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clrStb,
  input  logic             wrStb,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] key,
  output logic             hit
);

  logic [WIDTH-1:0] dataQ;
  logic             validQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ <= 1'b0;
    end else if (clrStb) begin
      validQ <= 1'b0;
    end else if (wrStb) begin
      validQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrStb && !clrStb) begin
      dataQ <= wrData;
    end
  end

  assign hit = validQ && (dataQ == key);

  AST_CLEAR_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
    clrStb |=> !validQ); // R7
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (wrStb && !clrStb) |=> (validQ && dataQ == $past(wrData))); // R2

endmodule

// File: rtl/cam_datapath.sv
module cam_datapath
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 8,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  camStrobe_t         stb,
  input  logic [WIDTH-1:0]   searchKey,
  input  logic [IDXW-1:0]    wrAddr,
  input  logic [WIDTH-1:0]   wrData,
  output logic [ENTRIES-1:0] matchVec,
  output logic               matchFound,
  output logic [IDXW-1:0]    matchIdx
);

  logic [ENTRIES-1:0] rawHit;
  logic [ENTRIES-1:0] lowestHit;
  logic [ENTRIES-1:0] nextVec;
  logic [IDXW-1:0]    nextIdx;

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    logic wrSel;
    assign wrSel = stb.doWrite && (wrAddr == IDXW'(i));
    cam_entry #(.WIDTH(WIDTH)) uEntry (
      .clk    (clk),
      .rst    (rst),
      .clrStb (stb.doClear),
      .wrStb  (wrSel),
      .wrData (wrData),
      .key    (searchKey),
      .hit    (rawHit[i])
    );
  end

  // Isolate the lowest set bit.
  assign lowestHit = rawHit & (~rawHit + ENTRIES'(1));
  assign nextVec   = stb.pickLowest ? lowestHit : rawHit;

  always_comb begin
    nextIdx = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (nextVec[k]) nextIdx = IDXW'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stb.doClear) begin
      matchVec   <= '0;
      matchFound <= 1'b0;
      matchIdx   <= '0;
    end else if (stb.doSearch) begin
      matchVec   <= nextVec;
      matchFound <= |rawHit;
      matchIdx   <= nextIdx;
    end
  end

  logic [ENTRIES-1:0] belowIdx;
  assign belowIdx = (ENTRIES'(1) << matchIdx) - ENTRIES'(1);

  AST_SINGLE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    (stb.doSearch && stb.pickLowest) |=> $onehot0(matchVec)); // R4
  AST_FOUND_IS_OR: assert property (@(posedge clk) disable iff (rst)
    matchFound == (matchVec != '0)); // R5
  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (rst)
    matchFound |-> (matchVec[matchIdx] && (matchVec & belowIdx) == '0)); // R5
  AST_IDX_ZERO_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    !matchFound |-> matchIdx == '0); // R5
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    stb.doClear |=> (matchVec == '0 && !matchFound)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!stb.doSearch && !stb.doClear) |=> ($stable(matchVec) && $stable(matchIdx))); // R9

endmodule

// File: rtl/cam_multimode.sv
module cam_multimode
  import cam_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 8,
  localparam int IDXW   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               opEn,
  input  logic [1:0]         opMode,
  input  logic [WIDTH-1:0]   searchKey,
  input  logic               wrEn,
  input  logic [IDXW-1:0]    wrAddr,
  input  logic [WIDTH-1:0]   wrData,
  output logic [ENTRIES-1:0] matchVec,
  output logic               matchFound,
  output logic [IDXW-1:0]    matchIdx
);

  camStrobe_t stb;

  cam_ctrl uCtrl (
    .clk    (clk),
    .rst    (rst),
    .opEn   (opEn),
    .opMode (opMode),
    .wrEn   (wrEn),
    .stb    (stb)
  );

  cam_datapath #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) uData (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .searchKey  (searchKey),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .matchVec   (matchVec),
    .matchFound (matchFound),
    .matchIdx   (matchIdx)
  );

endmodule

// File: tb/cam_multimode_bench.sv
module cam_multimode_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opEn = 1'b0;
  logic [1:0]  opMode = 2'b11;
  logic [7:0]  searchKey = '0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [15:0] matchVec;
  logic        matchFound;
  logic [3:0]  matchIdx;

  always #4 clk = ~clk;

  cam_multimode u_cam_multimode (
    .clk(clk), .rst(rst), .opEn(opEn), .opMode(opMode), .searchKey(searchKey),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .matchVec(matchVec), .matchFound(matchFound), .matchIdx(matchIdx)
  );

  typedef struct {
    int          due;
    logic [15:0] vec;
    logic        found;
    logic [3:0]  idx;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  int          cycle = 0;
  int          testsRun = 0;
  int          testsFailed = 0;
  logic [7:0]  modelMem[16];
  logic [15:0] modelValid = '0;
  logic [15:0] lastVec = '0;
  logic [3:0]  lastIdx = '0;

  always @(posedge clk) cycle <= cycle + 1;

  // Monitor: pop and compare items that fall due at this falling edge.
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due == cycle) begin
      expItem_t e;
      e = expQ.pop_front();
      testsRun++;
      if (matchVec !== e.vec || matchFound !== e.found || matchIdx !== e.idx) begin
        testsFailed++;
        $display("FAIL %s: vec=%h found=%b idx=%0d expected vec=%h found=%b idx=%0d",
                 e.tag, matchVec, matchFound, matchIdx, e.vec, e.found, e.idx);
      end
    end
  end

  function automatic logic [3:0] lowIdx(input logic [15:0] v);
    for (int k = 15; k >= 0; k--) if (v[k]) lowIdx = 4'(k);
    if (v == '0) lowIdx = '0;
  endfunction

  // Driver: called at a falling edge, returns at the next falling edge.
  task automatic step(input bit en, input logic [1:0] md, input logic [7:0] key,
                      input bit we, input logic [3:0] wa, input logic [7:0] wd,
                      input string tag);
    expItem_t e;
    logic [15:0] hits;
    hits = '0;
    for (int i = 0; i < 16; i++) if (modelValid[i] && modelMem[i] == key) hits[i] = 1'b1;
    if (en && md == 2'b00) begin
      lastVec = hits & (~hits + 16'd1);   // R4 lowest only
    end else if (en && md == 2'b01) begin
      lastVec = hits;                     // R3 all hits
    end else if (en && md == 2'b10) begin
      lastVec = '0;                       // R7
    end                                   // else R9 hold
    lastIdx = lowIdx(lastVec);
    e.due = cycle + 1; e.vec = lastVec; e.found = |lastVec; e.idx = lastIdx; e.tag = tag;
    expQ.push_back(e);
    opEn = en; opMode = md; searchKey = key; wrEn = we; wrAddr = wa; wrData = wd;
    if (en && md == 2'b10) modelValid = '0;
    else if (we) begin
      modelMem[wa] = wd;
      modelValid[wa] = 1'b1;
    end
    @(negedge clk);
    opEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    step(1'b0, 2'b11, 8'h00, 1'b1, a, d, tag);
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    testsRun++;
    if (matchVec !== '0 || matchFound !== 1'b0 || matchIdx !== '0) begin
      testsFailed++;
      $display("FAIL R1 reset: vec=%h found=%b idx=%0d expected all zero",
               matchVec, matchFound, matchIdx);
    end
    rst = 1'b0;
    step(1'b1, 2'b01, 8'h00, 1'b0, 0, 0, "R1_R6 empty array key 00");
    step(1'b1, 2'b01, 8'hA5, 1'b0, 0, 0, "R1 empty array key A5");
    wr(4'd3, 8'hA5, "R2 write e3");
    wr(4'd7, 8'hA5, "R2 write e7");
    wr(4'd12, 8'hA5, "R2 write e12");
    wr(4'd5, 8'h3C, "R2 write e5");
    wr(4'd15, 8'h00, "R2 write e15");
    step(1'b1, 2'b01, 8'hA5, 1'b0, 0, 0, "R3 multi three hits");
    step(1'b1, 2'b00, 8'hA5, 1'b0, 0, 0, "R4 single lowest of three");
    step(1'b1, 2'b00, 8'h3C, 1'b0, 0, 0, "R4_R5 single idx5");
    step(1'b1, 2'b01, 8'h00, 1'b0, 0, 0, "R6 key 00 only valid e15");
    step(1'b1, 2'b01, 8'h11, 1'b0, 0, 0, "R5 miss idx zero");
    step(1'b1, 2'b01, 8'hA5, 1'b0, 0, 0, "R3 multi again");
    step(1'b0, 2'b01, 8'h3C, 1'b0, 0, 0, "R9 opEn low holds");
    step(1'b1, 2'b11, 8'h3C, 1'b0, 0, 0, "R9 mode 11 holds");
    step(1'b1, 2'b01, 8'h3C, 1'b1, 4'd5, 8'h77, "R8 search sees old e5");
    step(1'b1, 2'b01, 8'h3C, 1'b0, 0, 0, "R8 old byte gone");
    step(1'b1, 2'b01, 8'h77, 1'b0, 0, 0, "R8 new byte visible");
    step(1'b1, 2'b10, 8'h00, 1'b1, 4'd0, 8'h55, "R7 clear with write");
    step(1'b1, 2'b01, 8'h55, 1'b0, 0, 0, "R7 discarded write no hit");
    step(1'b1, 2'b01, 8'hA5, 1'b0, 0, 0, "R7 cleared no hit");
    step(1'b1, 2'b01, 8'h00, 1'b0, 0, 0, "R6 cleared key 00");
    wr(4'd9, 8'hC3, "R2 write after clear");
    step(1'b1, 2'b00, 8'hC3, 1'b0, 0, 0, "R2 hit after clear");
    lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      logic [1:0] md;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      md = (lfsr[7:4] == 4'h0) ? 2'b10 : lfsr[1:0];
      step(lfsr[2] | lfsr[3], md, {6'b0, lfsr[9:8]}, lfsr[11], lfsr[15:12],
           {6'b0, lfsr[6:5]}, "R3_R4_R9 mixed traffic");
    end
    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(8 * 100000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule